// File: doc/BRIEF.md
# Transaction ID Match Filter

This block sits between the transaction monitor of an interconnect port and the event counters behind it. Every observed transaction arrives as a one-cycle strobe. The strobe carries an 11-bit destination identifier, an 11-bit origin identifier and a single trace-marker flag. The block decides whether the transaction counts and produces a qualified pulse one clock later.

Three tests are available, and each has its own enable:
- an inclusive window on the destination identifier;
- a masked equality test on the origin identifier;
- a requirement that the trace marker be set.

A global gate sits above the three enables. While the gate is off, every transaction is counted and the three enables have no effect. While it is on, a transaction is counted only if every enabled test passes. Software programs the tests through three write-only configuration words, picked by a 2-bit selector.

Top module: `txn_id_filter`

## Requirements
- R1: After reset all configuration is clear and `hit_o` is 0. With the reset configuration, every strobe on `txn_vld_i` produces a pulse.
- R2: `hit_o` goes high exactly one clock after the qualifying strobe and lasts one cycle. It never goes high unless `txn_vld_i` was high in the previous cycle.
- R3: While the global gate (control bit 1) is clear, every strobe passes, whatever the three per-test enables hold.
- R4: With the destination test enabled (control bit 5), a strobe passes the test only when low ≤ `txn_dst_i` ≤ high, inclusive at both ends.
- R5: A destination window whose high bound is 0, or whose high bound is below its low bound, rejects every strobe while the destination test is enabled.
- R6: With the origin test enabled (control bit 4), a strobe passes the test when `txn_src_i` equals the compare value in every bit where the mask bit is 1. A zero mask passes every identifier.
- R7: With the trace test enabled (control bit 2), a strobe passes the test only when `txn_tag_i` is 1.
- R8: With the gate set, a strobe produces a pulse only when every enabled test passes (logical AND).
- R9: `cfg_sel_i` selects a configuration word: 0 is control, 1 is origin, 2 is destination, and 3 is ignored. In the destination word, the low bound sits at bits 11:1 and the high bound at bits 22:12. In the origin word, the compare value sits at bits 11:1 and the mask at bits 22:12. Control bits other than 1, 2, 4 and 5 have no effect.
- R10: Writing zero to an identifier word and clearing that test's enable returns the filter to passing every strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 2 | Configuration word select |
| cfg_wdata_i | input | 32 | Configuration write data |
| txn_vld_i | input | 1 | Transaction observed this cycle |
| txn_dst_i | input | 11 | Destination identifier |
| txn_src_i | input | 11 | Origin identifier |
| txn_tag_i | input | 1 | Trace marker |
| hit_o | output | 1 | Qualified event pulse, one cycle after the strobe |

## Verification
The embedded assertions check the following on every cycle:
- a pulse never appears without a preceding strobe;
- an ungated strobe always yields a pulse;
- a strobe that fails the enabled trace test, or meets an enabled but invalid destination window, never yields one.

Only the bench scenarios can show the rest:
- the exact inclusive edges of the window;
- the bit-level effect of the mask;
- the field placement in the configuration words;
- the ignored selector;
- the AND across several enabled tests.

// File: rtl/txn_id_filter.sv
module txn_id_filter #(
  parameter int ID_W   = 11,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we_i,
  input  logic [1:0]        cfg_sel_i,
  input  logic [DATA_W-1:0] cfg_wdata_i,
  input  logic              txn_vld_i,
  input  logic [ID_W-1:0]   txn_dst_i,
  input  logic [ID_W-1:0]   txn_src_i,
  input  logic              txn_tag_i,
  output logic              hit_o
);

  localparam int LO_LSB = 1;
  localparam int HI_LSB = LO_LSB + ID_W;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_SRC  = 2'd1;
  localparam logic [1:0] SEL_DST  = 2'd2;

  localparam int B_GATE = 1;
  localparam int B_TAG  = 2;
  localparam int B_SRC  = 4;
  localparam int B_DST  = 5;

  logic gate_q, tag_en_q, src_en_q, dst_en_q;
  logic [ID_W-1:0] cmp_q, msk_q, lo_q, hi_q;
  logic armed_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gate_q   <= 1'b0;
      tag_en_q <= 1'b0;
      src_en_q <= 1'b0;
      dst_en_q <= 1'b0;
      cmp_q    <= '0;
      msk_q    <= '0;
      lo_q     <= '0;
      hi_q     <= '0;
    end else if (cfg_we_i) begin
      case (cfg_sel_i)
        SEL_CTRL: begin
          gate_q   <= cfg_wdata_i[B_GATE];
          tag_en_q <= cfg_wdata_i[B_TAG];
          src_en_q <= cfg_wdata_i[B_SRC];
          dst_en_q <= cfg_wdata_i[B_DST];
        end
        SEL_SRC: begin
          cmp_q <= cfg_wdata_i[LO_LSB +: ID_W];
          msk_q <= cfg_wdata_i[HI_LSB +: ID_W];
        end
        SEL_DST: begin
          lo_q <= cfg_wdata_i[LO_LSB +: ID_W];
          hi_q <= cfg_wdata_i[HI_LSB +: ID_W];
        end
        default: ;
      endcase
    end
  end

  wire win_ok = (hi_q != '0) && (hi_q >= lo_q);
  wire dst_ok = !dst_en_q || (win_ok && txn_dst_i >= lo_q && txn_dst_i <= hi_q);
  wire src_ok = !src_en_q || (((txn_src_i ^ cmp_q) & msk_q) == '0);
  wire tag_ok = !tag_en_q || txn_tag_i;
  wire qual   = txn_vld_i && (!gate_q || (dst_ok && src_ok && tag_ok));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit_o   <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      hit_o   <= qual;
      armed_q <= 1'b1;
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(!rst_n) |-> !hit_o);

  assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q && hit_o |-> $past(txn_vld_i));

  assert_ungated_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q && $past(txn_vld_i && !gate_q) |-> hit_o);

  assert_bad_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q && $past(gate_q && dst_en_q && (hi_q == '0 || hi_q < lo_q)) |-> !hit_o);

  assert_tag_block_R7: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q && $past(gate_q && tag_en_q && !txn_tag_i) |-> !hit_o);

endmodule

// File: tb/tb_txn_id_filter.sv
module tb_txn_id_filter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [1:0]  cfg_sel_i = '0;
  logic [31:0] cfg_wdata_i = '0;
  logic        txn_vld_i = 1'b0;
  logic [10:0] txn_dst_i = '0;
  logic [10:0] txn_src_i = '0;
  logic        txn_tag_i = 1'b0;
  logic        hit_o;

  int n_run = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  txn_id_filter dut (
    .clk(clk), .rst_n(rst_n), .cfg_we_i(cfg_we_i), .cfg_sel_i(cfg_sel_i),
    .cfg_wdata_i(cfg_wdata_i), .txn_vld_i(txn_vld_i), .txn_dst_i(txn_dst_i),
    .txn_src_i(txn_src_i), .txn_tag_i(txn_tag_i), .hit_o(hit_o)
  );

  typedef struct packed {
    logic gate, en_tag, en_src, en_dst;
    logic [10:0] cmp, msk, lo, hi, dst, src;
    logic tag, exp;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t TBL [NV] = '{
    '{1'b0,1'b1,1'b1,1'b1, 11'h005,11'h7FF,11'd10,11'd20, 11'd100,11'h000, 1'b0,1'b1}, // R3
    '{1'b1,1'b0,1'b0,1'b1, 11'h000,11'h000,11'd10,11'd20, 11'd10, 11'h000, 1'b0,1'b1}, // R4 low edge
    '{1'b1,1'b0,1'b0,1'b1, 11'h000,11'h000,11'd10,11'd20, 11'd20, 11'h000, 1'b0,1'b1}, // R4 high edge
    '{1'b1,1'b0,1'b0,1'b1, 11'h000,11'h000,11'd10,11'd20, 11'd21, 11'h000, 1'b0,1'b0}, // R4 above
    '{1'b1,1'b0,1'b0,1'b1, 11'h000,11'h000,11'd10,11'd20, 11'd9,  11'h000, 1'b0,1'b0}, // R4 below
    '{1'b1,1'b0,1'b0,1'b1, 11'h000,11'h000,11'd0, 11'h7FF,11'h7FF,11'h000, 1'b0,1'b1}, // R4 full span
    '{1'b1,1'b0,1'b0,1'b1, 11'h000,11'h000,11'd0, 11'd0,  11'd0,  11'h000, 1'b0,1'b0}, // R5 high zero
    '{1'b1,1'b0,1'b0,1'b1, 11'h000,11'h000,11'd30,11'd20, 11'd25, 11'h000, 1'b0,1'b0}, // R5 inverted
    '{1'b1,1'b0,1'b1,1'b0, 11'h0A5,11'h0F0,11'd0, 11'd0,  11'd0,  11'h7AF, 1'b0,1'b1}, // R6 masked eq
    '{1'b1,1'b0,1'b1,1'b0, 11'h0A5,11'h0F0,11'd0, 11'd0,  11'd0,  11'h7BF, 1'b0,1'b0}, // R6 masked ne
    '{1'b1,1'b0,1'b1,1'b0, 11'h3C3,11'h000,11'd0, 11'd0,  11'd0,  11'h124, 1'b0,1'b1}, // R6 zero mask
    '{1'b1,1'b1,1'b0,1'b0, 11'h000,11'h000,11'd0, 11'd0,  11'd0,  11'h000, 1'b0,1'b0}, // R7 no tag
    '{1'b1,1'b1,1'b0,1'b0, 11'h000,11'h000,11'd0, 11'd0,  11'd0,  11'h000, 1'b1,1'b1}, // R7 tag
    '{1'b1,1'b1,1'b1,1'b1, 11'h055,11'h0FF,11'd5, 11'd50, 11'd40, 11'h655, 1'b0,1'b0}, // R8 tag fails
    '{1'b1,1'b1,1'b1,1'b1, 11'h055,11'h0FF,11'd5, 11'd50, 11'd51, 11'h655, 1'b1,1'b0}, // R8 window fails
    '{1'b1,1'b1,1'b1,1'b1, 11'h055,11'h0FF,11'd5, 11'd50, 11'd40, 11'h655, 1'b1,1'b1}  // R8 all pass
  };

  task automatic check(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: hit_o=%0b expected %0b", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we_i = 1'b1; cfg_sel_i = sel; cfg_wdata_i = d;
    @(negedge clk);
    cfg_we_i = 1'b0;
  endtask

  function automatic logic [31:0] ctrl_w(logic g, logic t, logic s, logic d);
    return (32'(g) << 1) | (32'(t) << 2) | (32'(s) << 4) | (32'(d) << 5);
  endfunction

  function automatic logic [31:0] id_w(logic [10:0] a, logic [10:0] b);
    return (32'(a) << 1) | (32'(b) << 12);
  endfunction

  task automatic send(input string req, input logic [10:0] d, input logic [10:0] s,
                      input logic t, input logic exp);
    @(negedge clk);
    txn_vld_i = 1'b1; txn_dst_i = d; txn_src_i = s; txn_tag_i = t;
    @(posedge clk); #1;
    check(req, hit_o, exp);
    @(negedge clk);
    txn_vld_i = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: hit_o=%0b expected completion", hit_o);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk); #1;
    check("R1 out during reset", hit_o, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    send("R1 reset config passes", 11'd3, 11'd7, 1'b0, 1'b1);

    for (int i = 0; i < NV; i++) begin
      wr(2'd0, ctrl_w(TBL[i].gate, TBL[i].en_tag, TBL[i].en_src, TBL[i].en_dst));
      wr(2'd1, id_w(TBL[i].cmp, TBL[i].msk));
      wr(2'd2, id_w(TBL[i].lo, TBL[i].hi));
      send($sformatf("table[%0d]", i), TBL[i].dst, TBL[i].src, TBL[i].tag, TBL[i].exp);
    end

    // R2 latency and single-cycle width
    wr(2'd0, 32'd0);
    @(negedge clk);
    txn_vld_i = 1'b1;
    #0.5 check("R2 not combinational", hit_o, 1'b0);
    @(posedge clk); #1;
    check("R2 one cycle later", hit_o, 1'b1);
    @(negedge clk); txn_vld_i = 1'b0;
    @(posedge clk); #1;
    check("R2 pulse ends", hit_o, 1'b0);
    @(posedge clk); #1;
    check("R2 no strobe no pulse", hit_o, 1'b0);

    // R9 selector 3 ignored and unused control bits
    wr(2'd0, ctrl_w(1, 1, 0, 0));
    send("R9 tag blocks", 11'd0, 11'd0, 1'b0, 1'b0);
    wr(2'd3, 32'd0);
    send("R9 selector 3 ignored", 11'd0, 11'd0, 1'b0, 1'b0);
    wr(2'd0, 32'hFFFF_FFC9);
    send("R9 unused control bits", 11'd0, 11'd0, 1'b0, 1'b1);

    // R10 clearing a criterion restores pass-all
    wr(2'd1, id_w(11'h005, 11'h7FF));
    wr(2'd0, ctrl_w(1, 0, 1, 0));
    send("R10 origin rejects", 11'd0, 11'h000, 1'b0, 1'b0);
    wr(2'd1, 32'd0);
    wr(2'd0, ctrl_w(1, 0, 0, 0));
    send("R10 cleared passes", 11'd0, 11'h000, 1'b0, 1'b1);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule